// File: doc/BRIEF.md
# Read-Gate Training Sequencer

This block runs one read-gate (DQS squelch) calibration pass on a DRAM PHY with two byte lanes, and keeps the memory refreshed around it. A start pulse makes it save the controller's current refresh-interval value and then write zero to that register, so that no periodic refresh can fire while the PHY searches for the gate position. It raises the PHY's calibration request, waits a settle time, and then polls the per-lane completion flags until every lane reports done.

Once calibration ends, the block drops the request. It then sends a fixed burst of all-rank refresh commands to the command issuer, one handshake at a time, to make up the refresh time lost during calibration. After the last command is acknowledged it writes the saved interval back and gives a one-cycle done pulse. A cycle-count timeout guards the polling phase. When it fires, an error flag is set and the same clean-up path (drop the request, refresh burst, restore) still runs.

Top module: `gate_train_seq`

## Requirements
- R1: On an accepted start, the block captures `refi_rd_i`. In the next cycle it writes zero to the refresh interval (`refi_wr_en_o`=1, `refi_wr_data_o`=0) before `cal_ctrl_o` bit 0 rises. Exactly one zero write is made per run.
- R2: `cal_ctrl_o` has two bits. Bit 0 requests calibration and bit 1 selects the mode, with 0 meaning normal mode. During calibration the field reads 2'b01; at all other times it reads 2'b00. Bit 1 is never set.
- R3: After the request is raised, the lane flags are ignored for exactly `SETTLE_CYC` cycles. If all flags are already set, bit 0 stays high for `SETTLE_CYC`+1 cycles.
- R4: Calibration ends only when every bit of `lane_done_i` is set. Bit 1 is the high byte lane and bit 0 is the low byte lane. Either lane alone keeps the request high and issues no refresh.
- R5: `cal_ctrl_o` bit 0 is low in every cycle in which `ref_req_o` is high.
- R6: After calibration, exactly `NUM_REF` (default 3) refresh commands are issued with `ref_rank_o`=2'b11. Each one is counted on a cycle where `ref_req_o` and `ref_ack_i` are both high, and `ref_req_o` stays high until that cycle.
- R7: The saved interval is written back (`refi_wr_en_o`=1 with the captured value) exactly once, and only after the last refresh has been acknowledged.
- R8: If the flags are not all set within `TIMEOUT_CYC` polling cycles, `timeout_o` is set and the request is dropped after `SETTLE_CYC`+`TIMEOUT_CYC` cycles. The refresh burst and the restore still follow. `timeout_o` holds until the next accepted start clears it.
- R9: A start pulse that arrives while a run is in progress is ignored. There is no second capture, no second zero write and no second done pulse.
- R10: After reset all outputs are low. `done_o` is a single-cycle pulse, given once per run after the restore write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| refi_rd_i | input | REFI_W | Current refresh-interval register value |
| refi_wr_en_o | output | 1 | Refresh-interval write strobe |
| refi_wr_data_o | output | REFI_W | Refresh-interval write value |
| cal_ctrl_o | output | 2 | Calibration control: bit 0 start, bit 1 mode (0 = normal) |
| lane_done_i | input | LANES | Per-lane calibration done flags |
| ref_req_o | output | 1 | Refresh command request |
| ref_rank_o | output | RANK_W | Rank mask for the refresh command |
| ref_ack_i | input | 1 | Command issuer accepted the request |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Calibration timed out on the last run |

## Verification
The bench checks the ordering of the interval writes against calibration and refresh. A design that restores the interval too early, or skips the zero write, lets refresh run during calibration; the bench detects this from when the writes occur and what data they carry. It holds a single lane done for many cycles, which exposes a design that accepts either lane, and it sets the flags before the request so that a missing or shortened settle window shows up as a wrong request length. It also slows the acknowledge, runs a timeout, and sends a second start pulse during a busy run. A wrong burst count, a lost timeout flag, a skipped restore after timeout, or a re-capture on the ignored start each leave a count or a data value at the ports that differs from the expected one.

// File: rtl/gts_pkg.sv
// Shared types for the read-gate training sequencer.
// Assumes: none beyond the IEEE 1800-2017 language.
package gts_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,     // waiting for start
        ST_ZERO,     // write zero to refresh interval
        ST_SETTLE,   // request raised, flags not yet looked at
        ST_POLL,     // request raised, waiting for all lanes
        ST_STOP,     // request dropped
        ST_REF,      // catch-up refresh burst
        ST_RESTORE,  // write saved interval back
        ST_FIN       // done pulse
    } gts_state_e;
endpackage

// File: rtl/gts_cycle_timer.sv
// Cycle timer: counts while run is high and flags the LIMIT-th cycle.
// Assumes: LIMIT >= 1; run low clears the count.
module gts_cycle_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign hit = run && (cnt == LAST);

    // Count run cycles; hold at the last value, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (!hit)      cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/gts_ref_burst.sv
// Refresh burst issuer: while go is high, keeps the request up and counts
// the acknowledges; last marks the acknowledge of the final command.
// Assumes: go stays high until last; the issuer acks with a one-cycle pulse.
module gts_ref_burst #(
    parameter int NUM_REF = 3,
    parameter int RANK_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              ack,
    output logic              req,
    output logic [RANK_W-1:0] rank,
    output logic              last
);
    localparam int CW = (NUM_REF > 1) ? $clog2(NUM_REF) : 1;
    localparam logic [CW-1:0] LAST = CW'(NUM_REF - 1);

    logic [CW-1:0] sent;

    assign req  = go;
    assign rank = go ? {RANK_W{1'b1}} : '0;
    assign last = go && ack && (sent == LAST);

    // Count accepted commands within the burst.
    always_ff @(posedge clk) begin
        if (!rst_n || !go)    sent <= '0;
        else if (ack && !last) sent <= sent + 1'b1;
    end
endmodule

// File: rtl/gate_train_seq.sv
// Read-gate training sequencer: saves and zeroes the refresh interval, runs
// one PHY gate calibration with settle and timeout, issues a catch-up
// refresh burst, restores the interval and pulses done.
// Assumes: the refresh-interval value on refi_rd_i is valid at start.
module gate_train_seq #(
    parameter int REFI_W      = 16,
    parameter int LANES       = 2,
    parameter int RANK_W      = 2,
    parameter int SETTLE_CYC  = 8,
    parameter int TIMEOUT_CYC = 4096,
    parameter int NUM_REF     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [REFI_W-1:0] refi_rd_i,
    output logic              refi_wr_en_o,
    output logic [REFI_W-1:0] refi_wr_data_o,
    output logic [1:0]        cal_ctrl_o,
    input  logic [LANES-1:0]  lane_done_i,
    output logic              ref_req_o,
    output logic [RANK_W-1:0] ref_rank_o,
    input  logic              ref_ack_i,
    output logic              done_o,
    output logic              timeout_o
);
    import gts_pkg::*;

    localparam logic CAL_MODE_NORMAL = 1'b0;

    gts_state_e        state, state_nx;
    logic [REFI_W-1:0] saved_refi;
    logic              settle_hit, tmo_hit, ref_last, all_done;

    assign all_done = &lane_done_i;

    gts_cycle_timer #(.LIMIT(SETTLE_CYC)) u_settle (
        .clk(clk), .rst_n(rst_n), .run(state == ST_SETTLE), .hit(settle_hit));

    gts_cycle_timer #(.LIMIT(TIMEOUT_CYC)) u_tmo (
        .clk(clk), .rst_n(rst_n), .run(state == ST_POLL), .hit(tmo_hit));

    gts_ref_burst #(.NUM_REF(NUM_REF), .RANK_W(RANK_W)) u_burst (
        .clk(clk), .rst_n(rst_n), .go(state == ST_REF), .ack(ref_ack_i),
        .req(ref_req_o), .rank(ref_rank_o), .last(ref_last));

    // Next-state selection for the sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start_i) state_nx = ST_ZERO;
            ST_ZERO:    state_nx = ST_SETTLE;
            ST_SETTLE:  if (settle_hit) state_nx = ST_POLL;
            ST_POLL:    if (all_done || tmo_hit) state_nx = ST_STOP;
            ST_STOP:    state_nx = ST_REF;
            ST_REF:     if (ref_last) state_nx = ST_RESTORE;
            ST_RESTORE: state_nx = ST_FIN;
            ST_FIN:     state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Capture the refresh interval on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)                          saved_refi <= '0;
        else if (state == ST_IDLE && start_i) saved_refi <= refi_rd_i;
    end

    // Timeout flag: set on expiry, cleared by the next accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)                           timeout_o <= 1'b0;
        else if (state == ST_IDLE && start_i) timeout_o <= 1'b0;
        else if (state == ST_POLL && tmo_hit && !all_done) timeout_o <= 1'b1;
    end

    // Output decode from state.
    always_comb begin
        refi_wr_en_o   = (state == ST_ZERO) || (state == ST_RESTORE);
        refi_wr_data_o = (state == ST_RESTORE) ? saved_refi : '0;
        cal_ctrl_o     = {CAL_MODE_NORMAL,
                          (state == ST_SETTLE) || (state == ST_POLL)};
        done_o         = (state == ST_FIN);
    end
endmodule

// File: rtl/gts_checker.sv
// Property checker for the read-gate training sequencer, bound to the top.
// Assumes: tmo_hit is the top's internal timeout-expiry signal.
module gts_checker #(
    parameter int REFI_W = 16,
    parameter int LANES  = 2,
    parameter int RANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cal_ctrl_o,
    input logic [LANES-1:0]  lane_done_i,
    input logic              refi_wr_en_o,
    input logic [REFI_W-1:0] refi_wr_data_o,
    input logic              ref_req_o,
    input logic [RANK_W-1:0] ref_rank_o,
    input logic              done_o,
    input logic              tmo_hit
);
    p_zero_before_cal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_ctrl_o[0]) |-> ($past(refi_wr_en_o) && $past(refi_wr_data_o) == '0));

    p_normal_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_ctrl_o[1]);

    p_wait_all_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_ctrl_o[0] && !(&lane_done_i) && !tmo_hit) |=> cal_ctrl_o[0]);

    p_no_ref_in_cal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req_o |-> !cal_ctrl_o[0]);

    p_all_ranks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req_o |-> (ref_rank_o == {RANK_W{1'b1}}));

    p_no_write_in_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req_o |-> !refi_wr_en_o);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

bind gate_train_seq gts_checker #(.REFI_W(REFI_W), .LANES(LANES), .RANK_W(RANK_W))
    u_chk (.*);

// File: tb/sim_gate_train_seq.sv
// Directed bench for the read-gate training sequencer.
module sim_gate_train_seq;
    localparam int SETTLE  = 4;
    localparam int TMO     = 50;
    localparam int NREF    = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] refi_rd_i = '0;
    logic        refi_wr_en_o;
    logic [15:0] refi_wr_data_o;
    logic [1:0]  cal_ctrl_o;
    logic [1:0]  lane_done_i = '0;
    logic        ref_req_o;
    logic [1:0]  ref_rank_o;
    logic        ref_ack_i = 1'b0;
    logic        done_o;
    logic        timeout_o;

    int checks = 0;
    int errors = 0;

    // Monitor records, owned by the monitor process.
    logic mon_clr = 1'b0;
    int   ack_dly = 0;
    int   ack_wait, acks, n_zero, n_restore, cal_cycles, done_cnt, acks_at_restore;
    logic [15:0] restore_data;
    logic cal_before_zero, bad_code, req_in_cal, rank_bad, dbl_done, prev_done;

    always #5 clk = ~clk;

    gate_train_seq #(.REFI_W(16), .LANES(2), .RANK_W(2), .SETTLE_CYC(SETTLE),
                     .TIMEOUT_CYC(TMO), .NUM_REF(NREF)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .refi_rd_i(refi_rd_i),
        .refi_wr_en_o(refi_wr_en_o), .refi_wr_data_o(refi_wr_data_o),
        .cal_ctrl_o(cal_ctrl_o), .lane_done_i(lane_done_i),
        .ref_req_o(ref_req_o), .ref_rank_o(ref_rank_o), .ref_ack_i(ref_ack_i),
        .done_o(done_o), .timeout_o(timeout_o));

    // Monitor and acknowledge responder, both on the falling edge.
    always @(negedge clk) begin
        if (mon_clr) begin
            acks = 0; n_zero = 0; n_restore = 0; cal_cycles = 0; done_cnt = 0;
            acks_at_restore = -1; restore_data = '0; ack_wait = 0;
            cal_before_zero = 0; bad_code = 0; req_in_cal = 0; rank_bad = 0;
            dbl_done = 0; prev_done = 0; ref_ack_i = 0;
        end else begin
            if (refi_wr_en_o && acks == 0 && cal_cycles == 0 && refi_wr_data_o == 16'h0) n_zero++;
            else if (refi_wr_en_o) begin
                n_restore++; restore_data = refi_wr_data_o; acks_at_restore = acks;
            end
            if (cal_ctrl_o == 2'b01) begin
                cal_cycles++;
                if (n_zero == 0) cal_before_zero = 1;
            end
            if (cal_ctrl_o[1]) bad_code = 1;
            if (ref_req_o && cal_ctrl_o[0]) req_in_cal = 1;
            if (ref_req_o && ref_rank_o != 2'b11) rank_bad = 1;
            if (done_o) begin
                done_cnt++;
                if (prev_done) dbl_done = 1;
            end
            prev_done = done_o;
            if (ref_ack_i) begin
                ref_ack_i = 0; ack_wait = 0;
            end else if (ref_req_o) begin
                if (ack_wait >= ack_dly) begin ref_ack_i = 1; acks++; end
                else ack_wait++;
            end
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        tick(); mon_clr = 1'b1; tick(); mon_clr = 1'b0;
    endtask

    task automatic pulse_start(input logic [15:0] refi);
        refi_rd_i = refi; start_i = 1'b1; tick(); start_i = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (done_cnt == 0 && n < 2000) begin tick(); n++; end
        chk(done_cnt != 0, req, done_cnt, 1);
        tick(5);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!refi_wr_en_o && cal_ctrl_o == 2'b00 && !ref_req_o && !done_o && !timeout_o,
            "R10 reset outputs", {refi_wr_en_o, cal_ctrl_o, ref_req_o, done_o, timeout_o}, 0);
    endtask

    task automatic t_basic();
        clear_mon(); ack_dly = 0; lane_done_i = 2'b11;
        pulse_start(16'h0618);
        refi_rd_i = 16'hBEEF;
        wait_done("R10 done reached");
        chk(n_zero == 1 && !cal_before_zero, "R1 zero write first", n_zero, 1);
        chk(!bad_code, "R2 mode bit", bad_code, 0);
        chk(cal_cycles == SETTLE + 1, "R3 settle length", cal_cycles, SETTLE + 1);
        chk(!req_in_cal, "R5 request dropped before refresh", req_in_cal, 0);
        chk(acks == NREF && !rank_bad, "R6 refresh count", acks, NREF);
        chk(n_restore == 1 && acks_at_restore == NREF, "R7 restore after burst", acks_at_restore, NREF);
        chk(restore_data == 16'h0618, "R7 restore value", restore_data, 16'h0618);
        chk(done_cnt == 1 && !dbl_done, "R10 single done pulse", done_cnt, 1);
        chk(!timeout_o, "R8 no timeout", timeout_o, 0);
    endtask

    task automatic t_lanes();
        clear_mon(); ack_dly = 3; lane_done_i = 2'b00;
        pulse_start(16'h0123);
        tick(10);
        lane_done_i = 2'b01; tick(20);
        @(negedge clk);
        chk(cal_ctrl_o == 2'b01 && !ref_req_o, "R4 low lane alone", cal_ctrl_o, 1);
        tick(); lane_done_i = 2'b10; tick(20);
        @(negedge clk);
        chk(cal_ctrl_o == 2'b01 && !ref_req_o, "R4 high lane alone", cal_ctrl_o, 1);
        tick(); lane_done_i = 2'b11;
        wait_done("R4 completes on both lanes");
        chk(acks == NREF && !req_in_cal, "R6 slow acknowledge count", acks, NREF);
        chk(acks_at_restore == NREF && restore_data == 16'h0123, "R7 restore slow ack",
            restore_data, 16'h0123);
    endtask

    task automatic t_timeout();
        clear_mon(); ack_dly = 1; lane_done_i = 2'b01;
        pulse_start(16'h0ABC);
        wait_done("R8 done after timeout");
        chk(timeout_o, "R8 timeout flag", timeout_o, 1);
        chk(cal_cycles == SETTLE + TMO, "R8 request length", cal_cycles, SETTLE + TMO);
        chk(acks == NREF && restore_data == 16'h0ABC && n_restore == 1,
            "R8 restore after timeout", restore_data, 16'h0ABC);
    endtask

    task automatic t_busy();
        clear_mon(); ack_dly = 0; lane_done_i = 2'b00;
        pulse_start(16'h1111);
        tick(3);
        pulse_start(16'h2222);
        tick(3);
        lane_done_i = 2'b11;
        wait_done("R9 run finishes");
        tick(20);
        chk(restore_data == 16'h1111, "R9 no recapture", restore_data, 16'h1111);
        chk(n_zero == 1 && done_cnt == 1, "R9 single run", done_cnt, 1);
        chk(!timeout_o, "R8 flag cleared by start", timeout_o, 0);
    endtask

    initial begin
        tick(3);
        t_reset();
        rst_n = 1'b1;
        tick(2);
        t_basic();
        t_lanes();
        t_timeout();
        t_busy();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule